// File: doc/BRIEF.md
# Handshaked Iterative GCD Unit

The block computes the greatest common divisor of two unsigned W-bit operands by repeated subtraction. An operand channel takes both operands together under one valid/ready pair. A result channel gives out the answer under a second valid/ready pair. The producer and the consumer can each stall for any number of cycles, so the unit fits any latency-insensitive pipeline.

Internally a three-state controller steps through idle, compute and done. Two working registers hold the operands. On each compute cycle the registers are either swapped, so the larger value sits in the first register, or the second register is subtracted from the first. When the second register reaches zero, the first register holds the result. The result stays on the output until the consumer takes it.

Top module: `gcd_handshake`

## Requirements
- R1: Operand and result width is the parameter W, default 16.
- R2: While reset is high, and at the first cycle after it is released, `op_ready` is 1 and `gcd_valid` is 0. Reset is asynchronous, active high, and aborts any computation in progress.
- R3: An operand pair is taken only at a rising edge where `op_valid` and `op_ready` are both 1. `op_ready` is 1 only in the idle state and drops to 0 the cycle after a transfer. While the block is computing or holding a result, `op_valid`, `op_a` and `op_b` have no effect.
- R4: For nonzero operands, the value presented with `gcd_valid` equals the greatest common divisor of the transferred pair.
- R5: While `gcd_valid` is 1 and `gcd_ready` is 0, `gcd_valid` stays 1 and `gcd_data` stays unchanged. The cycle after `gcd_ready` is sampled 1 together with `gcd_valid`, `gcd_valid` is 0 and `op_ready` is 1.
- R6: A zero second operand gives the first operand as the result. A zero first operand gives the second operand. Two zero operands give 0.
- R7: `op_ready` and `gcd_valid` are never 1 in the same cycle.
- R8: Each compute cycle performs exactly one step, either a swap (when first < second) or a subtraction (when the second is nonzero). `gcd_valid` is first seen 1 in the cycle that is (number of steps + 2) cycles after the transfer cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Asynchronous active-high reset |
| op_a | input | W | First operand |
| op_b | input | W | Second operand |
| op_valid | input | 1 | Operand pair is offered |
| op_ready | output | 1 | Block can take an operand pair |
| gcd_data | output | W | Result value |
| gcd_valid | output | 1 | Result is presented |
| gcd_ready | input | 1 | Consumer takes the result |

## Verification
The bench builds the block with the default W of 16. This puts the full-range extremes within reach: an all-ones pair of equal operands, and the pair 65535 and 1, whose single-step subtraction chain runs about 65 thousand cycles and so exercises the longest iteration the width allows. Random stalls on both channels, and stray operand offers while the block is busy, are mixed into every transaction. Every transaction also checks the step-count latency against a bench model of the swap/subtract sequence.

// File: rtl/gcd_handshake.sv
module gcd_handshake #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] op_a,
  input  logic [W-1:0] op_b,
  input  logic         op_valid,
  output logic         op_ready,
  output logic [W-1:0] gcd_data,
  output logic         gcd_valid,
  input  logic         gcd_ready
);

  typedef enum logic [1:0] {S_IDLE, S_CALC, S_DONE} state_t;

  state_t       state;
  logic [W-1:0] ra, rb;
  logic         need_swap, b_zero;

  assign b_zero    = (rb == '0);
  assign need_swap = (ra < rb);

  always_ff @(posedge clk or posedge rst) begin
    if (rst) begin
      state <= S_IDLE;
      ra    <= '0;
      rb    <= '0;
    end else begin
      case (state)
        S_IDLE: if (op_valid) begin
          ra    <= op_a;
          rb    <= op_b;
          state <= S_CALC;
        end
        S_CALC: begin
          if (need_swap) begin
            ra <= rb;
            rb <= ra;
          end else if (!b_zero) begin
            ra <= ra - rb;
          end else begin
            state <= S_DONE;
          end
        end
        S_DONE: if (gcd_ready) state <= S_IDLE;
        default: state <= S_IDLE;
      endcase
    end
  end

  assign op_ready  = (state == S_IDLE);
  assign gcd_valid = (state == S_DONE);
  assign gcd_data  = ra;

endmodule

// File: rtl/gcd_handshake_chk.sv
module gcd_handshake_chk #(
  parameter int W = 16
) (
  input logic         clk,
  input logic         rst,
  input logic         op_valid,
  input logic         op_ready,
  input logic [W-1:0] gcd_data,
  input logic         gcd_valid,
  input logic         gcd_ready
);

  assert_reset_quiet_R2: assert property (@(posedge clk) rst |-> (op_ready && !gcd_valid));

  assert_take_drops_ready_R3: assert property (@(posedge clk) disable iff (rst)
    (op_valid && op_ready) |=> !op_ready);

  assert_idle_waits_R3: assert property (@(posedge clk) disable iff (rst)
    (op_ready && !op_valid) |=> op_ready);

  assert_result_hold_R5: assert property (@(posedge clk) disable iff (rst)
    (gcd_valid && !gcd_ready) |=> (gcd_valid && $stable(gcd_data)));

  assert_result_release_R5: assert property (@(posedge clk) disable iff (rst)
    (gcd_valid && gcd_ready) |=> (!gcd_valid && op_ready));

  assert_channels_exclusive_R7: assert property (@(posedge clk) disable iff (rst)
    !(op_ready && gcd_valid));

endmodule

bind gcd_handshake gcd_handshake_chk #(.W(W)) u_chk (
  .clk(clk), .rst(rst), .op_valid(op_valid), .op_ready(op_ready),
  .gcd_data(gcd_data), .gcd_valid(gcd_valid), .gcd_ready(gcd_ready)
);

// File: tb/test_gcd_handshake.sv
module test_gcd_handshake;
  localparam int W = 16;
  localparam int NV = 8;
  localparam logic [W-1:0] VA [NV] = '{16'd48, 16'd18, 16'd17, 16'd100, 16'd1071, 16'd40960, 16'd65535, 16'd12};
  localparam logic [W-1:0] VB [NV] = '{16'd18, 16'd48, 16'd5,  16'd100, 16'd462,  16'd2560,  16'd65535, 16'd8};
  localparam logic [W-1:0] VE [NV] = '{16'd6,  16'd6,  16'd1,  16'd100, 16'd21,   16'd2560,  16'd65535, 16'd4};

  logic clk = 1'b0;
  logic rst;
  logic [W-1:0] op_a = '0, op_b = '0;
  logic op_valid = 1'b0, gcd_ready = 1'b0;
  logic op_ready, gcd_valid;
  logic [W-1:0] gcd_data;
  int n_chk = 0, n_fail = 0;

  always #2 clk = ~clk;

  gcd_handshake #(.W(W)) i_gcd_handshake (
    .clk(clk), .rst(rst), .op_a(op_a), .op_b(op_b), .op_valid(op_valid),
    .op_ready(op_ready), .gcd_data(gcd_data), .gcd_valid(gcd_valid), .gcd_ready(gcd_ready)
  );

  task automatic check(input bit ok, input string req, input string what, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic int model_steps(input int a, input int b);
    int n = 0;
    while (b != 0) begin
      if (a < b) begin int t = a; a = b; b = t; end
      else a = a - b;
      n++;
    end
    return n;
  endfunction

  task automatic run_vec(input logic [W-1:0] a, input logic [W-1:0] b, input logic [W-1:0] exp, input string req);
    int n, exp_n, stall;
    repeat ($urandom_range(0, 3)) @(negedge clk);
    check(op_ready, "R3", "ready before offer", int'(op_ready), 1);
    op_a = a; op_b = b; op_valid = 1'b1;
    @(negedge clk);
    op_valid = 1'b0;
    check(!op_ready, "R3", "ready after transfer", int'(op_ready), 0);
    op_a = ~a; op_b = a ^ 16'h5a5a;
    n = 1;
    while (!gcd_valid && n < 70000) begin
      op_valid = ($urandom_range(0, 3) == 0);
      @(negedge clk);
      n++;
    end
    op_valid = 1'b0;
    exp_n = model_steps(int'(a), int'(b)) + 2;
    check(gcd_valid, "R8", "result presented", int'(gcd_valid), 1);
    check(n == exp_n, "R8", "latency cycles", n, exp_n);
    check(gcd_data == exp, req, "result value", int'(gcd_data), int'(exp));
    check(!op_ready, "R7", "ready with valid", int'(op_ready), 0);
    stall = $urandom_range(0, 3);
    op_valid = 1'b1; op_a = 16'd3; op_b = 16'd9;
    for (int i = 0; i < stall; i++) begin
      @(negedge clk);
      check(gcd_valid && gcd_data == exp, "R5", "held result", int'(gcd_data), int'(exp));
    end
    op_valid = 1'b0;
    gcd_ready = 1'b1;
    @(negedge clk);
    gcd_ready = 1'b0;
    check(!gcd_valid, "R5", "valid after take", int'(gcd_valid), 0);
    check(op_ready, "R5", "ready after take", int'(op_ready), 1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    rst = 1'b1;
    repeat (3) @(negedge clk);
    check(op_ready && !gcd_valid, "R2", "in reset", int'({op_ready, gcd_valid}), 2);
    check($bits(gcd_data) == 16, "R1", "result width", $bits(gcd_data), 16);
    rst = 1'b0;
    @(negedge clk);
    check(op_ready && !gcd_valid, "R2", "after release", int'({op_ready, gcd_valid}), 2);

    for (int i = 0; i < NV; i++) run_vec(VA[i], VB[i], VE[i], "R4");

    run_vec(16'd65535, 16'd1, 16'd1, "R4");
    run_vec(16'd0, 16'd7, 16'd7, "R6");
    run_vec(16'd7, 16'd0, 16'd7, "R6");
    run_vec(16'd0, 16'd0, 16'd0, "R6");

    op_a = 16'd65535; op_b = 16'd1; op_valid = 1'b1;
    @(negedge clk);
    op_valid = 1'b0;
    repeat (10) @(negedge clk);
    rst = 1'b1;
    #1;
    check(op_ready && !gcd_valid, "R2", "mid-compute reset", int'({op_ready, gcd_valid}), 2);
    @(negedge clk);
    rst = 1'b0;
    run_vec(16'd9, 16'd6, 16'd3, "R2");

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule